// File: doc/BRIEF.md
# Supply monitor controller

This block is the digital side of a supply supervisor. Three comparator outputs come in from the analog front end: the supply is below the power-on rearm level, below the selected detect threshold, or below the selected warning threshold. Each passes through a two-stage synchronizer. From them the block generates the system reset. It also keeps a detect flag and a warning flag, each with its own interrupt request line, and it records why the last supply-related reset happened.

Software sees three byte-wide registers on a simple write-strobe, combinational-read port:

| Address | Contents |
|---------|----------|
| 0 | Detect control and flag |
| 1 | Warning control and flag |
| 2 | Reset-source status |

The detect comparator acts in one of two ways. With reset-enable set it resets the system. With reset-enable clear it only raises a flag and an interrupt. A reset caused by supply trouble is released only once the supply has recovered above the detect threshold. The two threshold-select bits drive outputs straight to the analog references.

A non-supply reset request clears the source record, and so does a test-only clear input. The block's own `rst_n` models first power-up.

Top module: `supmon_ctrl`

## Requirements
- R1: While `por_i` is 1, `sys_rst_n_o` is 0 at once, with no clock edge needed. Reset stays asserted while the synchronized detect input is 1. It releases at the third rising edge after the later of `por_i` and `lvd_i` falls (two synchronizer stages plus the hold register).
- R2: A power-on condition, or `rst_n` low, sets both source bits in address 2: bit 0 (power-on) and bit 1 (low-voltage). A power-on condition takes priority over any clear.
- R3: When address 0 bit 0 (enable) and bit 2 (reset-enable) are both 1 and `lvd_i` is 1, reset asserts at the third rising edge after `lvd_i` rises. It is held until `lvd_i` falls. This sets source bit 1 and leaves bit 0 unchanged.
- R4: `ext_rst_i` asserts reset at the next edge, holds it while high, and clears both source bits. `src_clr_i` clears both source bits without asserting reset.
- R5: With enable 1 and reset-enable 0, a detect condition sets the detect flag (address 0 bit 7). `irq_det_o` equals the flag ANDed with address 0 bit 1 (interrupt-enable). With enable 0, nothing sets the flag and no reset results.
- R6: Writing 1 to address 0 bit 6 clears the detect flag. Writing 0 leaves it set. Bit 6 always reads 0. If a set condition and a clearing write fall in the same cycle, the flag stays set.
- R7: With enable 1, the warning flag (address 1 bit 7) is set when the warning input is 1 and the detect input is 0. `irq_warn_o` equals that flag ANDed with address 1 bit 0. Writing 1 to address 1 bit 6 clears the flag.
- R8: `det_sel_o` follows address 0 bit 3 and `warn_sel_o` follows address 1 bit 1. While reset is held, both flags clear, the controls return to their defaults (address 0 reads 0x05, address 1 reads 0x00), and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset (first power-up) |
| por_i | input | 1 | Supply below power-on rearm level |
| lvd_i | input | 1 | Supply below selected detect threshold |
| lvw_i | input | 1 | Supply below selected warning threshold |
| ext_rst_i | input | 1 | Non-supply reset request |
| src_clr_i | input | 1 | Test clear of the reset-source bits |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| sys_rst_n_o | output | 1 | Active-low system reset |
| irq_det_o | output | 1 | Detect interrupt request |
| irq_warn_o | output | 1 | Warning interrupt request |
| det_en_o | output | 1 | Detect comparator enable |
| det_sel_o | output | 1 | Detect threshold select |
| warn_sel_o | output | 1 | Warning trip level select |

## Verification
The bound checker watches, on every cycle, several properties:
- the power-on input forcing reset;
- reset holding while the detect input remains low;
- both source bits being set after a power-on condition;
- the flags staying sticky unless acknowledged;
- every flag rise having a legal cause;
- the controls reverting to defaults during a hold.

Only the bench scenarios can show the rest:
- the exact release cycle;
- the interplay between ordering of resets and the source record;
- the same-cycle set-versus-acknowledge outcome seen through readback;
- the full set of enable, reset-enable and interrupt-enable combinations with their select outputs.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NSENSE = 3;
  localparam int SYNC_STAGES = 2;

  localparam logic [AW-1:0] A_DET  = 2'd0;
  localparam logic [AW-1:0] A_WARN = 2'd1;
  localparam logic [AW-1:0] A_SRC  = 2'd2;

  // detect control register bit positions
  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_RE   = 2;
  localparam int B_SEL  = 3;
  localparam int B_ACK  = 6;
  localparam int B_FLAG = 7;
  // warning control register bit positions
  localparam int BW_IE  = 0;
  localparam int BW_SEL = 1;
  // source status bit positions
  localparam int BS_POR = 0;
  localparam int BS_LVD = 1;

  // sensor vector index
  localparam int S_POR = 0;
  localparam int S_LVD = 1;
  localparam int S_LVW = 2;

  typedef struct packed {
    logic en;
    logic ie;
    logic re;
    logic sel;
  } det_cfg_t;

  typedef struct packed {
    logic ie;
    logic sel;
  } warn_cfg_t;

  localparam det_cfg_t  DET_DEF  = '{en: 1'b1, ie: 1'b0, re: 1'b1, sel: 1'b0};
  localparam warn_cfg_t WARN_DEF = '{ie: 1'b0, sel: 1'b0};
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end else begin : g_single
      always_comb stg_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/supmon_rstseq.sv
module supmon_rstseq (
  input  logic clk,
  input  logic rst_n,
  input  logic por_s,
  input  logic lvd_s,
  input  logic lvd_arm,
  input  logic ext_rst,
  input  logic src_clr,
  output logic hold_q,
  output logic src_por_q,
  output logic src_lvd_q
);
  logic hold_d, src_por_d, src_lvd_d;

  always_comb begin
    // hold continues on a low detect input once entered, whatever the enables
    hold_d    = por_s | ext_rst | (lvd_s & (hold_q | lvd_arm));
    src_por_d = src_por_q;
    src_lvd_d = src_lvd_q;
    if (por_s) begin
      src_por_d = 1'b1;
      src_lvd_d = 1'b1;
    end else if (ext_rst || src_clr) begin
      src_por_d = 1'b0;
      src_lvd_d = 1'b0;
    end else if (lvd_s && lvd_arm) begin
      src_lvd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b1;
      src_por_q <= 1'b1;
      src_lvd_q <= 1'b1;
    end else begin
      hold_q    <= hold_d;
      src_por_q <= src_por_d;
      src_lvd_q <= src_lvd_d;
    end
  end
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          lvd_s,
  input  logic          lvw_s,
  input  logic          src_por,
  input  logic          src_lvd,
  output logic [DW-1:0] rdata,
  output det_cfg_t      det_cfg,
  output warn_cfg_t     warn_cfg,
  output logic          det_flag,
  output logic          warn_flag,
  output logic          irq_det,
  output logic          irq_warn
);
  det_cfg_t  det_q, det_d;
  warn_cfg_t warn_q, warn_d;
  logic det_flag_q, det_flag_d, warn_flag_q, warn_flag_d;
  logic det_we, warn_we, det_set, det_clr, warn_set, warn_clr;
  logic unused_wdata;

  assign det_we   = wr_en & (addr == A_DET)  & ~hold;
  assign warn_we  = wr_en & (addr == A_WARN) & ~hold;
  assign det_set  = det_q.en & ~det_q.re & lvd_s;
  assign det_clr  = det_we & wdata[B_ACK];
  assign warn_set = det_q.en & lvw_s & ~lvd_s;
  assign warn_clr = warn_we & wdata[B_ACK];
  assign unused_wdata = ^{wdata[7], wdata[5:4]};

  always_comb begin
    det_d  = det_q;
    warn_d = warn_q;
    if (hold) begin
      det_d  = DET_DEF;
      warn_d = WARN_DEF;
    end else begin
      if (det_we)  det_d  = '{en: wdata[B_EN], ie: wdata[B_IE], re: wdata[B_RE], sel: wdata[B_SEL]};
      if (warn_we) warn_d = '{ie: wdata[BW_IE], sel: wdata[BW_SEL]};
    end
  end

  always_comb begin
    if (hold)         det_flag_d = 1'b0;
    else if (det_set) det_flag_d = 1'b1;
    else if (det_clr) det_flag_d = 1'b0;
    else              det_flag_d = det_flag_q;

    if (hold)          warn_flag_d = 1'b0;
    else if (warn_set) warn_flag_d = 1'b1;
    else if (warn_clr) warn_flag_d = 1'b0;
    else               warn_flag_d = warn_flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q       <= DET_DEF;
      warn_q      <= WARN_DEF;
      det_flag_q  <= 1'b0;
      warn_flag_q <= 1'b0;
    end else begin
      det_q       <= det_d;
      warn_q      <= warn_d;
      det_flag_q  <= det_flag_d;
      warn_flag_q <= warn_flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DET: begin
        rdata[B_EN]   = det_q.en;
        rdata[B_IE]   = det_q.ie;
        rdata[B_RE]   = det_q.re;
        rdata[B_SEL]  = det_q.sel;
        rdata[B_FLAG] = det_flag_q;
      end
      A_WARN: begin
        rdata[BW_IE]  = warn_q.ie;
        rdata[BW_SEL] = warn_q.sel;
        rdata[B_FLAG] = warn_flag_q;
      end
      A_SRC: begin
        rdata[BS_POR] = src_por;
        rdata[BS_LVD] = src_lvd;
      end
      default: rdata = '0;
    endcase
  end

  assign det_cfg   = det_q;
  assign warn_cfg  = warn_q;
  assign det_flag  = det_flag_q;
  assign warn_flag = warn_flag_q;
  assign irq_det   = det_flag_q & det_q.ie;
  assign irq_warn  = warn_flag_q & warn_q.ie;
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_i,
  input  logic          lvd_i,
  input  logic          lvw_i,
  input  logic          ext_rst_i,
  input  logic          src_clr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sys_rst_n_o,
  output logic          irq_det_o,
  output logic          irq_warn_o,
  output logic          det_en_o,
  output logic          det_sel_o,
  output logic          warn_sel_o
);
  logic [NSENSE-1:0] sense_raw, sense_s;
  logic por_s, lvd_s, lvw_s;
  logic hold_q, src_por, src_lvd, det_flag, warn_flag;
  det_cfg_t  det_cfg;
  warn_cfg_t warn_cfg;

  always_comb begin
    sense_raw        = '0;
    sense_raw[S_POR] = por_i;
    sense_raw[S_LVD] = lvd_i;
    sense_raw[S_LVW] = lvw_i;
  end

  supmon_sync #(.W(NSENSE), .STAGES(SYNC_STAGES), .RST_VAL({NSENSE{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sense_raw), .q(sense_s)
  );

  assign por_s = sense_s[S_POR];
  assign lvd_s = sense_s[S_LVD];
  assign lvw_s = sense_s[S_LVW];

  supmon_rstseq u_rstseq (
    .clk(clk), .rst_n(rst_n), .por_s(por_s), .lvd_s(lvd_s),
    .lvd_arm(det_cfg.en & det_cfg.re), .ext_rst(ext_rst_i), .src_clr(src_clr_i),
    .hold_q(hold_q), .src_por_q(src_por), .src_lvd_q(src_lvd)
  );

  supmon_regs u_regs (
    .clk(clk), .rst_n(rst_n), .hold(hold_q), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .lvd_s(lvd_s), .lvw_s(lvw_s), .src_por(src_por),
    .src_lvd(src_lvd), .rdata(rdata_o), .det_cfg(det_cfg), .warn_cfg(warn_cfg),
    .det_flag(det_flag), .warn_flag(warn_flag), .irq_det(irq_det_o),
    .irq_warn(irq_warn_o)
  );

  // power-on input asserts reset without waiting for a clock edge
  assign sys_rst_n_o = ~(por_i | hold_q);
  assign det_en_o    = det_cfg.en;
  assign det_sel_o   = det_cfg.sel;
  assign warn_sel_o  = warn_cfg.sel;
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk
  import supmon_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          por_i,
  input logic          sys_rst_n_o,
  input logic          ext_rst_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          hold_q,
  input logic          por_s,
  input logic          lvd_s,
  input logic          lvw_s,
  input logic          src_por,
  input logic          src_lvd,
  input logic          det_flag,
  input logic          warn_flag,
  input logic          det_en,
  input logic          det_re
);
  p_por_forces_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |-> !sys_rst_n_o);

  p_hold_while_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && lvd_s) |=> !sys_rst_n_o);

  p_por_src_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> (src_por && src_lvd));

  p_ext_clears_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst_i && !por_s) |=> (!src_por && !src_lvd && !sys_rst_n_o));

  p_det_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(lvd_s && det_en && !det_re));

  p_det_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !hold_q && !(wr_en_i && addr_i == A_DET && wdata_i[B_ACK])) |=> det_flag);

  p_set_beats_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && det_en && !det_re && lvd_s) |=> det_flag);

  p_warn_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_flag) |-> $past(lvw_s && !lvd_s));

  p_hold_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (det_en && det_re && !det_flag && !warn_flag));
endmodule

bind supmon_ctrl supmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_i(por_i), .sys_rst_n_o(sys_rst_n_o),
  .ext_rst_i(ext_rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .hold_q(hold_q), .por_s(por_s), .lvd_s(lvd_s), .lvw_s(lvw_s),
  .src_por(src_por), .src_lvd(src_lvd), .det_flag(det_flag),
  .warn_flag(warn_flag), .det_en(det_cfg.en), .det_re(det_cfg.re)
);

// File: tb/tb_supmon_ctrl.sv
module tb_supmon_ctrl;
  logic clk, rst_n, por_i, lvd_i, lvw_i, ext_rst_i, src_clr_i, wr_en_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic sys_rst_n_o, irq_det_o, irq_warn_o, det_en_o, det_sel_o, warn_sel_o;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  supmon_ctrl dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // [15:12] detect cfg, [11:10] warn cfg, [9] lvd, [8] lvw,
  // [4] exp rst_n, [3] exp irq_det, [2] exp irq_warn, [1] exp det_sel, [0] exp warn_sel
  localparam logic [15:0] VEC [8] = '{
    16'h3514, 16'h3110, 16'h3718, 16'h1710,
    16'h7700, 16'h2710, 16'hBC13, 16'h3D15
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  initial begin
    rst_n = 1'b0; por_i = 1'b0; lvd_i = 1'b0; lvw_i = 1'b0;
    ext_rst_i = 1'b0; src_clr_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    step(3);
    chk("R8 reset held in block reset", {7'd0, sys_rst_n_o}, 8'h00);
    rst_n = 1'b1;
    step(2);
    chk("R1 still held before third edge", {7'd0, sys_rst_n_o}, 8'h00);
    step(1);
    chk("R1 release at third edge", {7'd0, sys_rst_n_o}, 8'h01);
    rd(2'd2, "R2 source bits after power-up", 8'h03);
    rd(2'd0, "R8 detect control default", 8'h05);
    rd(2'd1, "R8 warning control default", 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {4'h4, VEC[i][15:12]});
      wr(2'd1, {6'h10, VEC[i][11:10]});
      lvd_i = VEC[i][9]; lvw_i = VEC[i][8];
      step(4);
      chk($sformatf("R3 vec%0d rst_n", i), {7'd0, sys_rst_n_o}, {7'd0, VEC[i][4]});
      chk($sformatf("R5 vec%0d irq_det", i), {7'd0, irq_det_o}, {7'd0, VEC[i][3]});
      chk($sformatf("R7 vec%0d irq_warn", i), {7'd0, irq_warn_o}, {7'd0, VEC[i][2]});
      chk($sformatf("R8 vec%0d det_sel", i), {7'd0, det_sel_o}, {7'd0, VEC[i][1]});
      chk($sformatf("R8 vec%0d warn_sel", i), {7'd0, warn_sel_o}, {7'd0, VEC[i][0]});
      lvd_i = 1'b0; lvw_i = 1'b0;
      step(4);
    end

    // R1 power-on: async assert, hold while detect input low
    por_i = 1'b1; lvd_i = 1'b1;
    #1 chk("R1 async assert", {7'd0, sys_rst_n_o}, 8'h00);
    step(4);
    por_i = 1'b0;
    step(4);
    chk("R1 hold while below detect", {7'd0, sys_rst_n_o}, 8'h00);
    lvd_i = 1'b0;
    step(2);
    chk("R1 no early release", {7'd0, sys_rst_n_o}, 8'h00);
    step(1);
    chk("R1 release", {7'd0, sys_rst_n_o}, 8'h01);
    rd(2'd2, "R2 both bits after power-on", 8'h03);

    // R4 external reset clears source, R8 writes ignored during hold
    ext_rst_i = 1'b1;
    step(1);
    chk("R4 ext reset asserts", {7'd0, sys_rst_n_o}, 8'h00);
    rd(2'd2, "R4 ext reset clears source", 8'h00);
    wr(2'd1, 8'h03);
    rd(2'd1, "R8 write ignored in hold", 8'h00);
    ext_rst_i = 1'b0;
    step(1);
    chk("R4 ext release", {7'd0, sys_rst_n_o}, 8'h01);

    // R3 detect reset sets only low-voltage bit
    lvd_i = 1'b1;
    step(2);
    chk("R3 not yet", {7'd0, sys_rst_n_o}, 8'h01);
    step(1);
    chk("R3 detect reset", {7'd0, sys_rst_n_o}, 8'h00);
    lvd_i = 1'b0;
    step(3);
    chk("R3 released", {7'd0, sys_rst_n_o}, 8'h01);
    rd(2'd2, "R3 only low-voltage bit", 8'h02);

    src_clr_i = 1'b1;
    step(1);
    src_clr_i = 1'b0;
    rd(2'd2, "R4 test clear", 8'h00);
    chk("R4 test clear no reset", {7'd0, sys_rst_n_o}, 8'h01);

    // R6 acknowledge rules
    wr(2'd0, 8'h03);
    lvd_i = 1'b1;
    step(3);
    chk("R5 flag irq", {7'd0, irq_det_o}, 8'h01);
    lvd_i = 1'b0;
    step(3);
    wr(2'd0, 8'h03);
    rd(2'd0, "R6 write 0 keeps flag, ack reads 0", 8'h83);
    wr(2'd0, 8'h43);
    rd(2'd0, "R6 write 1 clears", 8'h03);
    chk("R6 irq dropped", {7'd0, irq_det_o}, 8'h00);
    lvd_i = 1'b1;
    step(3);
    wr(2'd0, 8'h43);
    rd(2'd0, "R6 set beats ack", 8'h83);
    lvd_i = 1'b0;
    step(3);
    wr(2'd0, 8'h43);
    rd(2'd0, "R6 later ack clears", 8'h03);

    // R7 warning flag readback and ack
    wr(2'd1, 8'h01);
    lvw_i = 1'b1;
    step(3);
    lvw_i = 1'b0;
    step(3);
    rd(2'd1, "R7 warn flag set", 8'h81);
    wr(2'd1, 8'h41);
    rd(2'd1, "R7 warn ack", 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule